// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block interprets one shared control input that carries two meanings. While the input is high, the high-speed output drivers are disabled and the loop logic is held in its power-down reset. When the input falls after it has been high long enough, a self-calibration sequence starts. The sequence clears the digital loop logic, requests a calibration and then waits through an acquisition window before it reports normal operation. A calibration only proceeds while the reference clock is valid and the supply is good. A falling edge that arrives while either condition is missing is remembered, and the sequence starts once both conditions are met.

The control input is asynchronous and passes through a two-flop synchronizer. All intervals are counted in reference-clock cycles and derived from a frequency parameter. The minimum high time is 1 µs, rounded up to whole cycles. The window from the start of the clear phase to normal operation is 1.5 ms. The clear and calibrate phases have parameterized lengths, and the acquisition phase fills the rest of the window. The loss-of-lock suppress output stays high at all times except during normal operation.

Top module: `pwrcal_seq`

## Requirements
- R1: After reset, and whenever the block is powered down, `drv_off_o` and `loop_rst_o` are 1, `lol_mask_o` is 1, and `cal_req_o`, `cal_busy_o` and `cal_done_o` are 0.
- R2: A rise of `pd_cal_i` that is held high makes `drv_off_o` go to 1 after the third rising clock edge, counting the first edge that samples the high level. `drv_off_o` is still 0 after the first and second of these edges.
- R3: A falling edge of the synchronized control input starts a sequence only if that input was high for at least MIN_HIGH = ceil(CLK_KHZ/1000) cycles. A shorter high pulse leaves the block powered down, with `drv_off_o` at 1.
- R4: If `ref_ok_i` or `sup_ok_i` is 0 at an accepted falling edge, the block waits with all of `drv_off_o`, `cal_busy_o` and `cal_req_o` at 0 and `lol_mask_o` at 1. The sequence starts in the cycle after both inputs are 1.
- R5: A sequence first asserts `loop_rst_o` for RST_CYC cycles. It then asserts `cal_req_o` for CAL_CYC cycles.
- R6: `cal_busy_o` is 1 for exactly WIN = CLK_KHZ*3/2 cycles, from the start of the clear phase until normal operation.
- R7: `cal_done_o` pulses for exactly one cycle, in the first cycle of normal operation.
- R8: `lol_mask_o` is 0 only during normal operation. It is 1 during power-down, while waiting, and throughout the sequence.
- R9: A synchronized high on the control input in any state returns the block to power-down. This takes priority over the end of the window, and in that case no `cal_done_o` pulse is issued.
- R10: If the reference or the supply is lost during the clear or calibrate phase, the block goes back to waiting and later restarts the full sequence. A loss during the acquisition phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_cal_i | input | 1 | Asynchronous control input: a high level means power-down, a qualified falling edge means calibrate |
| ref_ok_i | input | 1 | Reference clock valid |
| sup_ok_i | input | 1 | Supply above the calibration threshold |
| drv_off_o | output | 1 | Disable data and clock output drivers |
| loop_rst_o | output | 1 | Reset to the digital loop logic |
| cal_req_o | output | 1 | Request to the calibration engine |
| cal_busy_o | output | 1 | Sequence in progress |
| lol_mask_o | output | 1 | Suppress the loss-of-lock indication |
| cal_done_o | output | 1 | One-cycle pulse on entry to normal operation |

## Verification
The control input can rise in the same cycle in which the acquisition window expires, so an abort and the entry to normal operation compete for that cycle. The bench times the drive of the control input from its own model's window count, so that the synchronized high lands on the last cycle of the window. It then expects power-down and no completion pulse. A second coincidence places a loss of supply inside the acquisition phase, close to where the calibrate phase would end. The bench expects that loss to be ignored and the completion pulse to arrive on time.

// File: rtl/pwrcal_seq.sv
module pwrcal_seq #(
  parameter int CLK_KHZ = 19440,
  parameter int RST_CYC = 16,
  parameter int CAL_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_cal_i,
  input  logic ref_ok_i,
  input  logic sup_ok_i,
  output logic drv_off_o,
  output logic loop_rst_o,
  output logic cal_req_o,
  output logic cal_busy_o,
  output logic lol_mask_o,
  output logic cal_done_o
);
  localparam int MIN_HIGH = (CLK_KHZ + 999) / 1000;
  localparam int WIN_CYC  = (CLK_KHZ * 3) / 2;
  localparam int HW       = $clog2(MIN_HIGH + 1);
  localparam int TW       = $clog2(WIN_CYC + 1);
  localparam logic [HW-1:0] H_MAX   = HW'(MIN_HIGH);
  localparam logic [TW-1:0] CLR_END = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] CAL_END = TW'(RST_CYC + CAL_CYC - 1);
  localparam logic [TW-1:0] WIN_END = TW'(WIN_CYC - 1);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_CLR, S_CAL, S_ACQ, S_RUN} st_t;

  st_t st, nxt;
  logic [1:0] sync_q;
  logic pin_prev;
  logic [HW-1:0] hcnt;
  logic [TW-1:0] tcnt;
  logic done_q;

  wire pin  = sync_q[1];
  wire fall = pin_prev & ~pin;
  wire qual = (hcnt == H_MAX);
  wire ok   = ref_ok_i & sup_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b00;
      pin_prev <= 1'b0;
      hcnt     <= '0;
    end else begin
      sync_q   <= {sync_q[0], pd_cal_i};
      pin_prev <= pin;
      if (!pin)
        hcnt <= '0;
      else if (!qual)
        hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    nxt = st;
    unique case (st)
      S_OFF:  if (fall && qual) nxt = ok ? S_CLR : S_HOLD;
      S_HOLD: if (pin) nxt = S_OFF;
              else if (ok) nxt = S_CLR;
      S_CLR:  if (pin) nxt = S_OFF;
              else if (!ok) nxt = S_HOLD;
              else if (tcnt == CLR_END) nxt = S_CAL;
      S_CAL:  if (pin) nxt = S_OFF;
              else if (!ok) nxt = S_HOLD;
              else if (tcnt == CAL_END) nxt = S_ACQ;
      S_ACQ:  if (pin) nxt = S_OFF;
              else if (tcnt == WIN_END) nxt = S_RUN;
      S_RUN:  if (pin) nxt = S_OFF;
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      tcnt   <= '0;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (nxt == S_RUN) && (st != S_RUN);
      if (nxt == S_CLR && st != S_CLR)
        tcnt <= '0;
      else if (st == S_CLR || st == S_CAL || st == S_ACQ)
        tcnt <= tcnt + 1'b1;
    end
  end

  assign drv_off_o  = (st == S_OFF);
  assign loop_rst_o = (st == S_OFF) || (st == S_CLR);
  assign cal_req_o  = (st == S_CAL);
  assign cal_busy_o = (st == S_CLR) || (st == S_CAL) || (st == S_ACQ);
  assign lol_mask_o = (st != S_RUN);
  assign cal_done_o = done_q;
endmodule

module pwrcal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_cal_i,
  input logic drv_off_o,
  input logic loop_rst_o,
  input logic cal_req_o,
  input logic cal_busy_o,
  input logic lol_mask_o,
  input logic cal_done_o
);
  a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    drv_off_o |-> (loop_rst_o && !cal_busy_o && !cal_req_o && !cal_done_o));
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_off_o) |-> $past(pd_cal_i, 2));
  a_r5_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_req_o) |-> ($past(loop_rst_o) && !$past(drv_off_o)));
  a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |-> (cal_busy_o && !loop_rst_o));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);
  a_r7_done_run: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |-> (!lol_mask_o && $past(cal_busy_o)));
  a_r8_lol_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_off_o || cal_busy_o) |-> lol_mask_o);
endmodule

bind pwrcal_seq pwrcal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_cal_i(pd_cal_i),
  .drv_off_o(drv_off_o), .loop_rst_o(loop_rst_o), .cal_req_o(cal_req_o),
  .cal_busy_o(cal_busy_o), .lol_mask_o(lol_mask_o), .cal_done_o(cal_done_o)
);

// File: tb/test_pwrcal_seq.sv
module test_pwrcal_seq;
  localparam int TCLK = 10;
  localparam int KHZ = 4000;
  localparam int RST = 4;
  localparam int CAL = 32;
  localparam int MINH = (KHZ + 999) / 1000;
  localparam int WIN = (KHZ * 3) / 2;

  logic clk = 0, rst_n = 0, pin = 0, rok = 1, sok = 1;
  logic drv_off, loop_rst, cal_req, busy, lol_mask, done;
  int checks = 0, fails = 0, ended = 0;
  int done_cnt = 0, busy_cnt = 0, req_cnt = 0;

  // behavioural model: 0 off, 1 waiting, 2 sequence (timed by m_t)
  int m_s1 = 0, m_s2 = 0, m_prev = 0, m_hi = 0, m_mode = 0, m_t = 0, m_done = 0;

  pwrcal_seq #(.CLK_KHZ(KHZ), .RST_CYC(RST), .CAL_CYC(CAL)) i_pwrcal_seq (
    .clk(clk), .rst_n(rst_n), .pd_cal_i(pin), .ref_ok_i(rok), .sup_ok_i(sok),
    .drv_off_o(drv_off), .loop_rst_o(loop_rst), .cal_req_o(cal_req),
    .cal_busy_o(busy), .lol_mask_o(lol_mask), .cal_done_o(done));

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_hi = 0; m_mode = 0; m_t = 0; m_done = 0;
    end else begin
      int ok, fall, q, mode_n, t_n;
      ok = rok && sok;
      fall = m_prev && !m_s2;
      q = (m_hi >= MINH);
      mode_n = m_mode; t_n = m_t; m_done = 0;
      if (m_mode == 0) begin
        if (fall && q) begin mode_n = ok ? 2 : 1; t_n = 0; end
      end else if (m_s2) mode_n = 0;
      else if (m_mode == 1) begin
        if (ok) begin mode_n = 2; t_n = 0; end
      end else if (!ok && m_t < RST + CAL) mode_n = 1;
      else if (m_t < WIN) begin
        t_n = m_t + 1;
        if (t_n == WIN) m_done = 1;
      end
      m_hi = m_s2 ? ((m_hi < MINH) ? m_hi + 1 : m_hi) : 0;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
      m_mode = mode_n; m_t = t_n;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !ended) begin
    int seq;
    seq = (m_mode == 2);
    chk("R1 drv_off", drv_off, m_mode == 0);
    chk("R5 loop_rst", loop_rst, m_mode == 0 || (seq && m_t < RST));
    chk("R5 cal_req", cal_req, seq && m_t >= RST && m_t < RST + CAL);
    chk("R6 busy", busy, seq && m_t < WIN);
    chk("R8 lol_mask", lol_mask, !(seq && m_t >= WIN));
    chk("R7 done", done, m_done != 0);
    if (done) done_cnt++;
    if (busy) busy_cnt++;
    if (cal_req) req_cnt++;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    pin = 1; cyc(n); pin = 0;
  endtask

  task automatic summary();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      summary();
    end
  end

  initial begin
    int d0, b0, r0;
    cyc(3);
    chk("R1 reset drv_off", drv_off, 1);
    chk("R1 reset lol_mask", lol_mask, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1;
    cyc(2);

    // full calibration
    d0 = done_cnt; b0 = busy_cnt; r0 = req_cnt;
    pulse(MINH + 2);
    cyc(4);
    chk("R3 qualified start", busy, 1);
    cyc(WIN + 10);
    chk("R6 busy length", busy_cnt - b0 == WIN, 1);
    chk("R5 cal_req length", req_cnt - r0 == CAL, 1);
    chk("R7 single done", done_cnt - d0 == 1, 1);
    chk("R8 running unmasked", lol_mask, 0);

    // R2 synchronizer latency, then short pulse
    pin = 1;
    cyc(1); chk("R2 edge1", drv_off, 0);
    cyc(1); chk("R2 edge2", drv_off, 0);
    cyc(1); chk("R2 edge3", drv_off, 1);
    pin = 0;
    cyc(10);
    chk("R3 short pulse stays off", drv_off, 1);
    chk("R3 short pulse no busy", busy, 0);

    // exact boundary pulse, supply blip in acquire, abort at window end
    d0 = done_cnt;
    pulse(MINH);
    cyc(4);
    chk("R3 boundary qualifies", busy, 1);
    cyc(RST + CAL + 10);
    sok = 0; cyc(5); sok = 1;
    chk("R10 acquire ignores supply", busy, 1);
    while (m_t != WIN - 3) @(negedge clk);
    pin = 1;
    cyc(5);
    chk("R9 abort at window end", drv_off, 1);
    chk("R9 no done on abort", done_cnt == d0, 1);
    chk("R9 masked", lol_mask, 1);

    // pending on missing reference
    rok = 0;
    cyc(5);
    pin = 0;
    cyc(10);
    chk("R4 pending drivers on", drv_off, 0);
    chk("R4 pending idle", busy, 0);
    chk("R4 pending masked", lol_mask, 1);
    rok = 1;
    cyc(3);
    chk("R4 start after ref", busy, 1);
    cyc(20);
    sok = 0;
    cyc(2);
    chk("R10 supply loss back to wait", busy, 0);
    chk("R10 no request", cal_req, 0);
    sok = 1;
    d0 = done_cnt;
    cyc(WIN + 10);
    chk("R10 restarted completes", done_cnt - d0 == 1, 1);
    chk("R8 unmasked after restart", lol_mask, 0);

    // abort during calibrate
    pulse(MINH + 4);
    cyc(RST + 12);
    pin = 1;
    cyc(5);
    chk("R9 abort in calibrate", drv_off, 1);
    chk("R9 request dropped", cal_req, 0);
    pin = 0;
    cyc(5);
    summary();
  end
endmodule